// File: doc/BRIEF.md
# Column Priority Readout Encoder

This block drains the hits of one pixel column. Each pixel raises a one-cycle request when it holds data. The block latches the request into a pending vector. A four-way priority tree reduces that vector to one winning pixel index and an any-pending flag. The lowest-numbered pending pixel always wins.

An end-of-column sequencer takes the winner and drives a one-hot select line to that pixel. On the next cycle it raises a read strobe toward the downstream packet builder, and holds the strobe until the builder acknowledges. The acknowledge clears the serviced pixel's pending bit. On the very next cycle the next pending pixel is selected, so a burst of hits is read out back to back, one pixel per select-and-strobe round.

The pixel address is a plain binary index, with pixel 0 at address 0. The address width is two bits per tree level, which is 6 bits for 48 pixels.

Top module: `col_prio_readout`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `valid_o`, `addr_o`, `sel_o` and `rd_strobe_o` are all zero and no request is pending.
- R2: When several pixels are pending, `addr_o` carries the binary index of the lowest-numbered pending pixel (pixel k reads as address k).
- R3: `valid_o` is high whenever at least one request is pending, including the one being serviced. When nothing is pending, `valid_o` is low and `addr_o` is zero.
- R4: A request sampled at a clock edge shows up after that edge as `valid_o`=1, `addr_o`=index and `sel_o`=1<<index, with `rd_strobe_o` low. One cycle later `rd_strobe_o` rises, and `sel_o` stays asserted.
- R5: `rd_strobe_o` stays high until a cycle with `rd_ack_i` high. An acknowledge given while no strobe is up is ignored: it clears nothing and does not shorten the sequence.
- R6: From the select until the end of the strobe, `addr_o` and `sel_o` hold their values even when new requests arrive, including requests from lower-numbered pixels.
- R7: After the acknowledging edge, the serviced request is cleared. On the following cycle the next pending pixel is already selected with `rd_strobe_o` low; if none is pending, the outputs return to idle.
- R8: Every pending pixel is read out exactly once, in ascending index order. This holds when all pixels request at the same time, with pixel 0 and the last pixel as the end cases.
- R9: A new request from the pixel being serviced, arriving on the acknowledge cycle, stays pending, and that pixel is selected again.
- R10: `sel_o` is at most one-hot, and it is nonzero exactly when `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NPIX | Per-pixel hit requests, one bit per pixel |
| rd_ack_i | input | 1 | Acknowledge from the packet builder that ends a strobe |
| valid_o | output | 1 | At least one request pending |
| addr_o | output | AW | Index of the pixel being serviced |
| sel_o | output | NPIX | One-hot select to the serviced pixel |
| rd_strobe_o | output | 1 | Read strobe to the packet builder |

## Verification
The bench aims at the ends of the index range (pixel 0 and pixel 47 in one burst, and a full 48-pixel burst). A tree that breaks ties wrongly or drops a padded branch would read these out of order or skip one. It injects a lower-numbered request in the middle of a strobe, which a design that re-encodes live would answer by jumping the address. It gives an acknowledge during the select cycle and while idle, where a careless sequencer would clear a hit that was never read. It also re-raises the serviced pixel on its own acknowledge cycle, which a design that lets the clear win would lose.

// File: rtl/col_prio_pkg.sv
package col_prio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_STB  = 2'd2
  } rd_state_t;

  // Number of four-way levels needed to cover n leaves (at least one).
  function automatic int quad_levels(input int n);
    int lv;
    int cap;
    lv  = 1;
    cap = 4;
    while (cap < n) begin
      cap = cap * 4;
      lv  = lv + 1;
    end
    return lv;
  endfunction

  // Flat offset of tree level l (0 = leaves) when levels are stacked.
  function automatic int quad_base(input int l, input int lvl);
    int b;
    b = 0;
    for (int k = 0; k < l; k++) b = b + (1 << (2 * (lvl - k)));
    return b;
  endfunction

endpackage

// File: rtl/prio_node4.sv
module prio_node4 (
  input  logic [3:0] req,
  output logic       hit,
  output logic [1:0] pick
);

  // Lower branch wins; pick is zero when no branch requests.
  always_comb begin
    hit = |req;
    if (req[0])      pick = 2'd0;
    else if (req[1]) pick = 2'd1;
    else if (req[2]) pick = 2'd2;
    else if (req[3]) pick = 2'd3;
    else             pick = 2'd0;
  end

endmodule

// File: rtl/prio_tree.sv
module prio_tree
  import col_prio_pkg::*;
#(
  parameter int NPIX = 48,
  parameter int LVL  = quad_levels(NPIX),
  parameter int AW   = 2 * LVL
) (
  input  logic [NPIX-1:0] req,
  output logic            any,
  output logic [AW-1:0]   idx
);

  localparam int NLEAF = 1 << (2 * LVL);
  localparam int TOT   = quad_base(LVL + 1, LVL);
  localparam int ROOT  = quad_base(LVL, LVL);

  logic [NLEAF-1:0] leaf;
  logic [TOT-1:0]   hit_all;
  logic [AW-1:0]    sub_all [TOT];

  // Pad the column up to a full power of four with idle leaves.
  always_comb begin
    leaf            = '0;
    leaf[NPIX-1:0]  = req;
  end

  assign hit_all[NLEAF-1:0] = leaf;

  for (genvar q = 0; q < NLEAF; q++) begin : g_leaf
    assign sub_all[q] = '0;
  end

  for (genvar l = 1; l <= LVL; l++) begin : g_lv
    localparam int NN  = 1 << (2 * (LVL - l));
    localparam int OFS = quad_base(l, LVL);
    localparam int CB  = quad_base(l - 1, LVL);
    for (genvar n = 0; n < NN; n++) begin : g_nd
      logic [1:0] pick;
      prio_node4 u_nd (
        .req (hit_all[CB + 4*n +: 4]),
        .hit (hit_all[OFS + n]),
        .pick(pick)
      );
      // Prefix this level's two bits onto the winning child's index.
      assign sub_all[OFS + n] = (AW'(pick) << (2 * (l - 1)))
                              | sub_all[CB + 4*n + int'(pick)];
    end
  end

  assign any = hit_all[ROOT];
  assign idx = sub_all[ROOT];

endmodule

// File: rtl/eoc_ctrl.sv
module eoc_ctrl
  import col_prio_pkg::*;
#(
  parameter int NPIX = 48,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enc_any,
  input  logic [AW-1:0]   enc_idx,
  input  logic            rd_ack_i,
  output logic            done_o,
  output logic            valid_o,
  output logic [AW-1:0]   addr_o,
  output logic [NPIX-1:0] sel_o,
  output logic            rd_strobe_o
);

  rd_state_t state;
  logic      load;

  assign done_o = (state == ST_STB) && rd_ack_i;
  assign load   = (state == ST_IDLE) || done_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      valid_o     <= 1'b0;
      addr_o      <= '0;
      sel_o       <= '0;
      rd_strobe_o <= 1'b0;
    end else if (load) begin
      rd_strobe_o <= 1'b0;
      if (enc_any) begin
        state   <= ST_SEL;
        valid_o <= 1'b1;
        addr_o  <= enc_idx;
        sel_o   <= NPIX'(1) << enc_idx;
      end else begin
        state   <= ST_IDLE;
        valid_o <= 1'b0;
        addr_o  <= '0;
        sel_o   <= '0;
      end
    end else if (state == ST_SEL) begin
      state       <= ST_STB;
      rd_strobe_o <= 1'b1;
    end
  end

endmodule

// File: rtl/col_prio_readout.sv
module col_prio_readout
  import col_prio_pkg::*;
#(
  parameter  int NPIX = 48,
  localparam int LVL  = quad_levels(NPIX),
  localparam int AW   = 2 * LVL
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIX-1:0] req_i,
  input  logic            rd_ack_i,
  output logic            valid_o,
  output logic [AW-1:0]   addr_o,
  output logic [NPIX-1:0] sel_o,
  output logic            rd_strobe_o
);

  logic [NPIX-1:0] pend_q;
  logic [NPIX-1:0] pend_nxt;
  logic            done;
  logic            enc_any;
  logic [AW-1:0]   enc_idx;

  // The new hit is ORed in after the clear, so a same-cycle re-hit survives.
  assign pend_nxt = (pend_q & ~(sel_o & {NPIX{done}})) | req_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  prio_tree #(.NPIX(NPIX), .LVL(LVL), .AW(AW)) u_tree (
    .req(pend_nxt),
    .any(enc_any),
    .idx(enc_idx)
  );

  eoc_ctrl #(.NPIX(NPIX), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enc_any    (enc_any),
    .enc_idx    (enc_idx),
    .rd_ack_i   (rd_ack_i),
    .done_o     (done),
    .valid_o    (valid_o),
    .addr_o     (addr_o),
    .sel_o      (sel_o),
    .rd_strobe_o(rd_strobe_o)
  );

endmodule

// File: rtl/col_prio_readout_chk.sv
module col_prio_readout_chk
  import col_prio_pkg::*;
#(
  parameter  int NPIX = 48,
  localparam int AW   = 2 * quad_levels(NPIX)
) (
  input logic            clk,
  input logic            rst,
  input logic [NPIX-1:0] req_i,
  input logic            rd_ack_i,
  input logic            valid_o,
  input logic [AW-1:0]   addr_o,
  input logic [NPIX-1:0] sel_o,
  input logic            rd_strobe_o
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!valid_o && addr_o == '0 && sel_o == '0 && !rd_strobe_o));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> addr_o == '0);

  assert_req_raises_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && |req_i) |=> valid_o);

  assert_select_then_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !rd_strobe_o) |=> rd_strobe_o);

  assert_strobe_targets_addr_R4: assert property (@(posedge clk) disable iff (rst)
    rd_strobe_o |-> (valid_o && sel_o == (NPIX'(1) << addr_o)));

  assert_strobe_held_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_o && !rd_ack_i) |=> rd_strobe_o);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_o && !rd_ack_i) |=> ($stable(addr_o) && $stable(sel_o)));

  assert_strobe_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_o && rd_ack_i) |=> !rd_strobe_o);

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o) && ((|sel_o) == valid_o));

endmodule

bind col_prio_readout col_prio_readout_chk #(.NPIX(NPIX)) u_chk (.*);

// File: tb/sim_col_prio_readout.sv
module sim_col_prio_readout;

  localparam int NPIX = 48;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NPIX-1:0] req_i = '0;
  logic            rd_ack_i = 1'b0;
  logic            valid_o;
  logic [AW-1:0]   addr_o;
  logic [NPIX-1:0] sel_o;
  logic            rd_strobe_o;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  col_prio_readout #(.NPIX(NPIX)) u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .rd_ack_i(rd_ack_i),
    .valid_o(valid_o), .addr_o(addr_o), .sel_o(sel_o), .rd_strobe_o(rd_strobe_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NPIX-1:0] m);
    req_i = m;
    step();
    req_i = '0;
  endtask

  task automatic idle_chk(input string tag);
    chk({tag, " valid"},  64'(valid_o), 64'd0);
    chk({tag, " addr"},   64'(addr_o), 64'd0);
    chk({tag, " sel"},    64'(sel_o), 64'd0);
    chk({tag, " strobe"}, 64'(rd_strobe_o), 64'd0);
  endtask

  // Entered when the select of pixel idx should be visible; leaves one cycle after the ack edge.
  task automatic serve(input int idx, input string tag);
    chk({tag, " R4 valid"},     64'(valid_o), 64'd1);
    chk({tag, " R2 addr"},      64'(addr_o), 64'(idx));
    chk({tag, " R10 sel"},      64'(sel_o), 64'd1 << idx);
    chk({tag, " R7 no strobe"}, 64'(rd_strobe_o), 64'd0);
    step();
    chk({tag, " R4 strobe"},    64'(rd_strobe_o), 64'd1);
    chk({tag, " R4 sel held"},  64'(sel_o), 64'd1 << idx);
    rd_ack_i = 1'b1;
    step();
    rd_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    idle_chk("R1 in reset");
    rst = 1'b0;
    step();
    idle_chk("R1 after reset");
  endtask

  task automatic t_single();
    pulse(NPIX'(1) << 17);
    chk("R4 addr single", 64'(addr_o), 64'd17);
    step();
    chk("R4 strobe single", 64'(rd_strobe_o), 64'd1);
    repeat (3) begin
      step();
      chk("R5 strobe waits ack", 64'(rd_strobe_o), 64'd1);
      chk("R5 addr waits ack", 64'(addr_o), 64'd17);
    end
    rd_ack_i = 1'b1;
    step();
    rd_ack_i = 1'b0;
    idle_chk("R3 R7 drained single");
  endtask

  task automatic t_priority();
    pulse((NPIX'(1) << 47) | (NPIX'(1) << 30) | (NPIX'(1) << 5) | NPIX'(1));
    serve(0,  "R2 R8 first");
    serve(5,  "R2 R8 second");
    serve(30, "R2 R8 third");
    serve(47, "R2 R8 last");
    idle_chk("R3 R8 after burst");
  endtask

  task automatic t_full();
    pulse('1);
    for (int i = 0; i < NPIX; i++) serve(i, "R8 full column");
    idle_chk("R8 full column drained");
  endtask

  task automatic t_stable();
    pulse(NPIX'(1) << 20);
    step();
    req_i = NPIX'(1) << 3;
    step();
    req_i = '0;
    chk("R6 addr frozen", 64'(addr_o), 64'd20);
    chk("R6 sel frozen", 64'(sel_o), 64'd1 << 20);
    chk("R6 strobe kept", 64'(rd_strobe_o), 64'd1);
    rd_ack_i = 1'b1;
    step();
    rd_ack_i = 1'b0;
    serve(3, "R7 R6 late lower request");
    idle_chk("R6 drained");
  endtask

  task automatic t_ack_ignored();
    pulse(NPIX'(1) << 9);
    rd_ack_i = 1'b1;
    step();
    rd_ack_i = 1'b0;
    chk("R5 ack in select ignored strobe", 64'(rd_strobe_o), 64'd1);
    chk("R5 ack in select ignored addr", 64'(addr_o), 64'd9);
    step();
    chk("R5 strobe still up", 64'(rd_strobe_o), 64'd1);
    chk("R5 still valid", 64'(valid_o), 64'd1);
    rd_ack_i = 1'b1;
    step();
    rd_ack_i = 1'b0;
    idle_chk("R5 after real ack");
    rd_ack_i = 1'b1;
    step();
    rd_ack_i = 1'b0;
    step();
    idle_chk("R5 idle ack ignored");
  endtask

  task automatic t_rehit();
    pulse(NPIX'(1) << 12);
    step();
    rd_ack_i = 1'b1;
    req_i    = NPIX'(1) << 12;
    step();
    rd_ack_i = 1'b0;
    req_i    = '0;
    serve(12, "R9 rehit reselected");
    idle_chk("R9 drained");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_single();
    t_priority();
    t_full();
    t_stable();
    t_ack_ignored();
    t_rehit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule